// File: doc/BRIEF.md
# NAND Flash Phase Sequencer

This block runs one complete NAND flash operation from a single request. Each request holds a first command byte, zero or more address bytes, an optional second command, and a data phase. The data phase is either a number of read beats or a number of write beats, and a length of zero means the request has no data phase. The block drives the chip-select, command-latch, address-latch, write-strobe and read-strobe pins, and it drives the shared data bus. Every cycle it shapes is set by small timing fields that stay static while a request is running.

Before each data phase the block holds chip select high for a guard delay. The length of this delay depends on what came before the data phase:
- after a command latch, the guard is the command guard;
- after an address latch, the guard is the address guard;
- in boot mode, the block also waits for the synchronised ready/busy line to go idle, and then waits an extra recovery delay.

Read bytes leave on a push-style FIFO port. Write bytes come from a source that the block advances with a take strobe.

Top module: `nand_phase_seq`

## Requirements
- R1: While in reset and while no request is running (`seq_busy` low), the pin outputs are idle: `cs_n`, `we_n` and `re_n` are 1, and `cle`, `ale` and `dq_oe` are 0.
- R2: Every command or address cycle lasts `t_wc` cycles (a value of 0 counts as 1). `we_n` is low for the first `t_wp` of those cycles. `cle` is high for a command and `ale` is high for an address for the whole cycle, and the byte is on `dq_out` with `dq_oe` high. Legal settings have `t_wp` < `t_wc`.
- R3: The order of cycles is: the first command, then `req_naddr` address bytes (0 to MAX_ADDR, least significant byte of `req_addr` first), then the second command if `req_cmd2_en` is set. The second command comes before the data phase, except for a write that has data; in that case it comes after the data. No latch cycle ever follows a read data phase.
- R4: A read beat lasts `t_rc` cycles (0 counts as 1). `re_n` is low from cycle `t_rea` of the beat up to the end of the beat. `dq_in` is sampled in the last cycle of the beat, and one cycle later `rd_push` pulses with that byte on `rd_byte`. Legal settings have `t_rea` < `t_rc`.
- R5: A write beat lasts `t_wc` cycles with `we_n` low for the first `t_wp` of them. `cle` and `ale` are low, `dq_out` carries `wr_data`, and `wr_take` is high in the last cycle of the beat.
- R6: When the last cycle before a data phase is a command latch, chip select is high for exactly `t_clr` cycles before the data phase starts. A value of 0 means the data phase starts on the next cycle.
- R7: When the last cycle before a data phase is an address latch, chip select is high for exactly `t_ar` cycles before the data phase starts. A value of 0 means no gap.
- R8: `rb_busy` passes through two synchronising flops. With `req_boot` set, after the guard the data phase waits for the synchronised busy to read 0, then for `t_rr` more cycles. It starts 3 + `t_rr` cycles after the first cycle in which `rb_busy` is 0. With `req_boot` clear, `rb_busy` has no effect.
- R9: `req_go` is taken only while `seq_busy` is low. `seq_busy` rises the cycle after it is taken, and `req_go` or new request fields while busy have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Start a request (taken when idle) |
| req_cmd1 | input | DW | First command byte |
| req_naddr | input | NA_W | Number of address cycles |
| req_addr | input | MAX_ADDR*DW | Address bytes, byte 0 first |
| req_cmd2_en | input | 1 | Issue a second command |
| req_cmd2 | input | DW | Second command byte |
| req_write | input | 1 | Data phase direction, 1 = write |
| req_len | input | CNT_W | Data beats, 0 = no data phase |
| req_boot | input | 1 | Wait for ready before data |
| t_wc | input | 4 | Write/latch cycle length |
| t_wp | input | 3 | Write strobe low time |
| t_rc | input | 4 | Read beat length |
| t_rea | input | 3 | Read strobe assertion delay |
| t_clr | input | 3 | Guard after command latch |
| t_ar | input | 3 | Guard after address latch |
| t_rr | input | 3 | Guard after ready sync |
| rb_busy | input | 1 | Device busy, active high, asynchronous |
| dq_in | input | DW | Data bus from device |
| wr_data | input | DW | Write byte source |
| seq_busy | output | 1 | A request is running |
| cs_n | output | 1 | Chip select, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DW | Data bus to device |
| dq_oe | output | 1 | Data bus drive enable |
| wr_take | output | 1 | Current write byte consumed |
| rd_push | output | 1 | Read byte valid |
| rd_byte | output | DW | Read byte |

## Verification
A request taken at the end of cycle c0-1 starts its first command in cycle c0. Latch k sees `we_n` rise in cycle c0 + k*t_wc + t_wp. The data phase begins at D = c0 + (latches)*t_wc + guard; in boot mode it begins instead at (first cycle `rb_busy` is 0) + 3 + `t_rr`. Read beat b pushes in cycle D + (b+1)*t_rc. The driver stores each expected byte together with this due cycle, and the monitor pops an entry at every `we_n` rise and at every `rd_push`. Each popped entry is compared on its byte, its latch kind and its cycle, so early, late, missing or extra events all fail.

// File: rtl/nand_phase_seq.sv
module nand_phase_seq #(
  parameter int DW       = 8,
  parameter int MAX_ADDR = 5,
  parameter int CNT_W    = 8,
  localparam int NA_W    = $clog2(MAX_ADDR + 1),
  localparam int AB_W    = MAX_ADDR * DW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  input  logic [DW-1:0]    req_cmd1,
  input  logic [NA_W-1:0]  req_naddr,
  input  logic [AB_W-1:0]  req_addr,
  input  logic             req_cmd2_en,
  input  logic [DW-1:0]    req_cmd2,
  input  logic             req_write,
  input  logic [CNT_W-1:0] req_len,
  input  logic             req_boot,
  input  logic [3:0]       t_wc,
  input  logic [2:0]       t_wp,
  input  logic [3:0]       t_rc,
  input  logic [2:0]       t_rea,
  input  logic [2:0]       t_clr,
  input  logic [2:0]       t_ar,
  input  logic [2:0]       t_rr,
  input  logic             rb_busy,
  input  logic [DW-1:0]    dq_in,
  input  logic [DW-1:0]    wr_data,
  output logic             seq_busy,
  output logic             cs_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             wr_take,
  output logic             rd_push,
  output logic [DW-1:0]    rd_byte
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_GRD, S_RBW, S_RRG, S_DATA, S_ENDC
  } st_t;

  st_t              st, tail_st, gd_st;
  logic [3:0]       k;
  logic [NA_W-1:0]  aidx, naddr_q;
  logic [CNT_W-1:0] beat, len_q;
  logic [AB_W-1:0]  addr_q;
  logic [DW-1:0]    cmd1_q, cmd2_q;
  logic             c2en_q, wr_q, boot_q;
  logic [2:0]       grd_q, lat_g;
  logic             bsy1, bsy2;

  logic [3:0] wper_m1, rper_m1;
  logic       wlast, rlast, dlast, c2_pre, has_data, wphase;

  assign wper_m1  = (t_wc == 4'd0) ? 4'd0 : t_wc - 4'd1;
  assign rper_m1  = (t_rc == 4'd0) ? 4'd0 : t_rc - 4'd1;
  assign wlast    = (k == wper_m1);
  assign rlast    = (k == rper_m1);
  assign dlast    = wr_q ? wlast : rlast;
  assign has_data = (len_q != '0);
  assign c2_pre   = c2en_q && !(wr_q && has_data);
  assign lat_g    = (st == S_ADDR) ? t_ar : t_clr;
  assign gd_st    = boot_q ? S_RBW : S_DATA;

  always_comb begin
    if (!has_data)          tail_st = S_IDLE;
    else if (lat_g != 3'd0) tail_st = S_GRD;
    else                    tail_st = gd_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy1 <= 1'b0;
      bsy2 <= 1'b0;
    end else begin
      bsy1 <= rb_busy;
      bsy2 <= bsy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      k       <= '0;
      aidx    <= '0;
      beat    <= '0;
      naddr_q <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      cmd1_q  <= '0;
      cmd2_q  <= '0;
      c2en_q  <= 1'b0;
      wr_q    <= 1'b0;
      boot_q  <= 1'b0;
      grd_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_go) begin
          st      <= S_CMD1;
          k       <= '0;
          aidx    <= '0;
          beat    <= '0;
          cmd1_q  <= req_cmd1;
          naddr_q <= req_naddr;
          addr_q  <= req_addr;
          c2en_q  <= req_cmd2_en;
          cmd2_q  <= req_cmd2;
          wr_q    <= req_write;
          len_q   <= req_len;
          boot_q  <= req_boot;
        end
        S_CMD1: if (wlast) begin
          k     <= '0;
          grd_q <= lat_g;
          if (naddr_q != '0) st <= S_ADDR;
          else if (c2_pre)   st <= S_CMD2;
          else               st <= tail_st;
        end else k <= k + 4'd1;
        S_ADDR: if (wlast) begin
          k      <= '0;
          grd_q  <= lat_g;
          addr_q <= addr_q >> DW;
          if (aidx == naddr_q - {{(NA_W-1){1'b0}}, 1'b1})
            st <= c2_pre ? S_CMD2 : tail_st;
          else
            aidx <= aidx + {{(NA_W-1){1'b0}}, 1'b1};
        end else k <= k + 4'd1;
        S_CMD2: if (wlast) begin
          k     <= '0;
          grd_q <= lat_g;
          st    <= tail_st;
        end else k <= k + 4'd1;
        S_GRD: if (k == {1'b0, grd_q} - 4'd1) begin
          k  <= '0;
          st <= gd_st;
        end else k <= k + 4'd1;
        S_RBW: if (!bsy2) begin
          k  <= '0;
          st <= (t_rr != 3'd0) ? S_RRG : S_DATA;
        end
        S_RRG: if (k == {1'b0, t_rr} - 4'd1) begin
          k  <= '0;
          st <= S_DATA;
        end else k <= k + 4'd1;
        S_DATA: if (dlast) begin
          k <= '0;
          if (beat == len_q - {{(CNT_W-1){1'b0}}, 1'b1}) begin
            beat <= '0;
            st   <= (wr_q && c2en_q) ? S_ENDC : S_IDLE;
          end else beat <= beat + {{(CNT_W-1){1'b0}}, 1'b1};
        end else k <= k + 4'd1;
        S_ENDC: if (wlast) begin
          k  <= '0;
          st <= S_IDLE;
        end else k <= k + 4'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign seq_busy = (st != S_IDLE);
  assign cle      = (st == S_CMD1) || (st == S_CMD2) || (st == S_ENDC);
  assign ale      = (st == S_ADDR);
  assign cs_n     = !(cle || ale || st == S_DATA);
  assign wphase   = cle || ale || (st == S_DATA && wr_q);
  assign we_n     = !(wphase && (k < {1'b0, t_wp}));
  assign re_n     = !(st == S_DATA && !wr_q && (k >= {1'b0, t_rea}));
  assign dq_oe    = wphase;
  assign wr_take  = (st == S_DATA) && wr_q && wlast;

  always_comb begin
    case (st)
      S_CMD1:         dq_out = cmd1_q;
      S_CMD2, S_ENDC: dq_out = cmd2_q;
      S_ADDR:         dq_out = addr_q[DW-1:0];
      S_DATA:         dq_out = wr_q ? wr_data : '0;
      default:        dq_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_push <= 1'b0;
      rd_byte <= '0;
    end else begin
      rd_push <= (st == S_DATA) && !wr_q && rlast;
      if ((st == S_DATA) && !wr_q && rlast) rd_byte <= dq_in;
    end
  end

endmodule

module nand_phase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_go,
  input logic seq_busy,
  input logic cs_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic wr_take,
  input logic rd_push
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (cs_n && we_n && re_n && !cle && !ale && !dq_oe));

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R3
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!cs_n && we_n && !cle && !ale && !dq_oe));

  // R4
  push_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> $past(!re_n));

  // R5
  take_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (!cs_n && we_n && !cle && !ale && dq_oe));

  // R9
  start_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(req_go));

endmodule

bind nand_phase_seq nand_phase_seq_chk u_chk (.*);

// File: tb/sim_nand_phase_seq.sv
`timescale 1ns/1ps
module sim_nand_phase_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_go = 1'b0;
  logic [7:0]  req_cmd1 = '0, req_cmd2 = '0;
  logic [2:0]  req_naddr = '0;
  logic [39:0] req_addr = '0;
  logic        req_cmd2_en = 1'b0, req_write = 1'b0, req_boot = 1'b0;
  logic [7:0]  req_len = '0;
  logic [3:0]  t_wc = 4'd2, t_rc = 4'd3;
  logic [2:0]  t_wp = 3'd1, t_rea = 3'd2, t_clr = 3'd2, t_ar = 3'd2, t_rr = 3'd2;
  logic        rb_busy = 1'b0;
  logic [7:0]  dq_in, wr_data;
  logic        seq_busy, cs_n, cle, ale, we_n, re_n, dq_oe, wr_take, rd_push;
  logic [7:0]  dq_out, rd_byte;

  int tests = 0, fails = 0, cyc = 0;
  int widx = 0, rd_beat = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  logic [1:0] lq_kind[$];
  logic [7:0] lq_byte[$];
  int         lq_cyc[$];
  string      lq_tag[$];
  logic [7:0] rq_byte[$];
  int         rq_cyc[$];

  always #2 clk = ~clk;

  nand_phase_seq u0 (.*);

  assign wr_data = 8'hC3 ^ 8'(widx);
  assign dq_in   = 8'h5A + 8'(rd_beat * 7);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!seq_busy) widx <= 0;
    else if (wr_take) widx <= widx + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && !we_n) ;
      if (!prev_we && we_n) begin
        if (lq_byte.size() == 0) chk(0, "R3", "unexpected latch byte", int'(dq_out), 0);
        else begin
          logic [1:0] kd; logic [7:0] b; int c; string tg;
          kd = lq_kind.pop_front(); b = lq_byte.pop_front();
          c = lq_cyc.pop_front(); tg = lq_tag.pop_front();
          chk({cle, ale} == kd, "R3", "latch kind {cle,ale}", int'({cle, ale}), int'(kd));
          chk(dq_out == b, tg, "latched byte", int'(dq_out), int'(b));
          chk(dq_oe, tg, "dq_oe during latch", int'(dq_oe), 1);
          chk(cyc == c, tg, "we_n rise cycle", cyc, c);
        end
      end
      if (rd_push) begin
        if (rq_byte.size() == 0) chk(0, "R3", "unexpected read push", int'(rd_byte), 0);
        else begin
          logic [7:0] b; int c;
          b = rq_byte.pop_front(); c = rq_cyc.pop_front();
          chk(rd_byte == b, "R4", "read byte", int'(rd_byte), int'(b));
          chk(cyc == c, "R4", "read push cycle", cyc, c);
        end
      end
      if (!seq_busy) rd_beat <= 0;
      else if (!prev_re && re_n) rd_beat <= rd_beat + 1;
    end
    prev_we <= we_n;
    prev_re <= re_n;
  end

  task automatic push_l(input logic [1:0] kd, input logic [7:0] b, input int c, input string tg);
    lq_kind.push_back(kd); lq_byte.push_back(b); lq_cyc.push_back(c); lq_tag.push_back(tg);
  endtask

  task automatic run(input logic [7:0] c1, input int na, input logic [39:0] ad,
                     input bit c2e, input logic [7:0] c2, input bit wr, input int len,
                     input bit boot, input bit bsy, input int bextra, input bit poke);
    int c0, W, R, L, g, E, D, Fb;
    bit c2pre;
    @(negedge clk);
    c0 = cyc + 1;
    W = (t_wc == 0) ? 1 : int'(t_wc);
    R = (t_rc == 0) ? 1 : int'(t_rc);
    c2pre = c2e && !(wr && len > 0);
    L = 1 + na + (c2pre ? 1 : 0);
    push_l(2'b10, c1, c0 + int'(t_wp), "R2");
    for (int i = 0; i < na; i++) push_l(2'b01, ad[8*i +: 8], c0 + (1 + i) * W + int'(t_wp), "R3");
    if (c2pre) push_l(2'b10, c2, c0 + (1 + na) * W + int'(t_wp), "R3");
    g = (len == 0) ? 0 : ((na > 0 && !c2pre) ? int'(t_ar) : int'(t_clr));
    E = c0 + L * W + g;
    Fb = E + bextra;
    D = boot ? Fb + 3 + int'(t_rr) : E;
    for (int b = 0; b < len; b++) begin
      if (wr) push_l(2'b00, 8'hC3 ^ 8'(b), D + b * W + int'(t_wp), "R5");
      else begin
        rq_byte.push_back(8'h5A + 8'(b * 7));
        rq_cyc.push_back(D + (b + 1) * R);
      end
    end
    if (wr && len > 0 && c2e) push_l(2'b10, c2, D + len * W + int'(t_wp), "R3");
    req_cmd1 = c1; req_naddr = 3'(na); req_addr = ad; req_cmd2_en = c2e; req_cmd2 = c2;
    req_write = wr; req_len = 8'(len); req_boot = boot; rb_busy = boot | bsy;
    req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    chk(seq_busy == 1'b1, "R9", "seq_busy after accept", int'(seq_busy), 1);
    forever begin
      if (!seq_busy) break;
      if (poke && cyc == c0 + 3) begin req_go = 1'b1; req_cmd1 = 8'hFF; req_write = ~wr; end
      else req_go = 1'b0;
      if (boot && cyc == Fb) rb_busy = 1'b0;
      if (len > 0 && (g > 0 || boot) && cyc == D - 1)
        chk(cs_n == 1'b1, boot ? "R8" : (g == int'(t_ar) && na > 0 && !c2pre ? "R7" : "R6"),
            "cs_n high before data", int'(cs_n), 1);
      if (len > 0 && cyc == D) chk(cs_n == 1'b0, boot ? "R8" : "R6", "cs_n low at data start", int'(cs_n), 0);
      @(negedge clk);
    end
    req_go = 1'b0; rb_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk(lq_byte.size() == 0, "R3", "latch events outstanding", lq_byte.size(), 0);
    chk(rq_byte.size() == 0, "R4", "read pushes outstanding", rq_byte.size(), 0);
    chk(cs_n && we_n && re_n && !dq_oe, "R1", "idle pins after request", int'({cs_n, we_n, re_n, dq_oe}), 4'b1110);
    lq_kind.delete(); lq_byte.delete(); lq_cyc.delete(); lq_tag.delete();
    rq_byte.delete(); rq_cyc.delete();
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R9", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, we_n, re_n, cle, ale, dq_oe, seq_busy} == 7'b1110000, "R1", "pins in reset",
        int'({cs_n, we_n, re_n, cle, ale, dq_oe, seq_busy}), 7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, we_n, re_n, cle, ale, dq_oe, seq_busy} == 7'b1110000, "R1", "pins after reset",
        int'({cs_n, we_n, re_n, cle, ale, dq_oe, seq_busy}), 7'b1110000);
    // R2 R3 R4 R6: page read, 3 addresses, confirm command, 3 beats
    run(8'h00, 3, 40'h00_0030_2010, 1, 8'h30, 0, 3, 0, 0, 0, 0);
    // R3: address input then second command, no data
    run(8'h80, 3, 40'h00_00AB_CDEF, 1, 8'h10, 1, 0, 0, 0, 0, 0);
    // R5 R7 R3: program with data before end command
    t_ar = 3'd3;
    run(8'h80, 2, 40'h00_0000_5577, 1, 8'h10, 1, 4, 0, 0, 0, 0);
    // R7 zero guard, R8 busy ignored without boot
    t_ar = 3'd0;
    run(8'h85, 5, 40'h11_2233_4455, 0, 8'h00, 1, 2, 0, 1, 0, 0);
    // R6 zero guard, no address
    t_clr = 3'd0;
    run(8'h70, 0, 40'h0, 0, 8'h00, 0, 1, 0, 0, 0, 0);
    // R8 boot wait with recovery delay
    t_clr = 3'd2; t_rr = 3'd3;
    run(8'h00, 2, 40'h00_0000_0102, 1, 8'h30, 0, 2, 1, 0, 5, 0);
    t_rr = 3'd0;
    run(8'h00, 1, 40'h00_0000_00EE, 1, 8'h30, 0, 1, 1, 0, 2, 0);
    // R2 R4 R6 with longer cycles
    t_wc = 4'd4; t_wp = 3'd2; t_rc = 4'd5; t_rea = 3'd1; t_clr = 3'd1;
    run(8'h05, 2, 40'h00_0000_9A8B, 1, 8'hE0, 0, 4, 0, 0, 0, 0);
    // R9 go while busy ignored
    run(8'h00, 2, 40'h00_0000_3344, 1, 8'h30, 0, 2, 0, 0, 0, 1);
    finish_up();
  end

endmodule